// File: doc/BRIEF.md
# Dual-Radix Digit Adder-Subtractor

This block is a purely combinational single-digit arithmetic unit. It takes two 4-bit operands, a carry/borrow input, an operation select and a radix select. It produces one 4-bit result digit, a carry/borrow output and a flag for a bad decimal operand.

In hexadecimal mode the digits are plain 4-bit binary values. In decimal mode they are BCD digits, and a correction stage turns the binary sum or difference back into a valid decimal digit. The carry or borrow output feeds the carry input of the next more significant digit, so wider numbers can be built from a chain of these units.

The datapath is a ripple of bit-level cells. Each bit has a full-adder cell and a full-subtractor cell, and the operation select picks which one drives that bit. The decimal correction reuses the same ripple structure to add or subtract the constant six.

Top module: `bcdhex_addsub`

## Requirements
- R1: With `dec_i`=0 and `sub_i`=0 (hex add), `{cy_o, dig_o}` equals `opa_i + opb_i + cy_i` as a 5-bit value, and `bad_o` is 0.
- R2: With `dec_i`=0 and `sub_i`=1 (hex subtract), `dig_o` equals `(opa_i - opb_i - cy_i) mod 16`. `cy_o` is 1 exactly when `opa_i < opb_i + cy_i`.
- R3: With `dec_i`=1, `sub_i`=0 and both operands in 0..9, `dig_o` equals `(opa_i + opb_i + cy_i) mod 10`. `cy_o` is 1 exactly when that sum is 10 or more.
- R4: With `dec_i`=1, `sub_i`=1 and both operands in 0..9, `dig_o` equals `(opa_i - opb_i - cy_i)`, plus 10 when that value is negative. `cy_o` is 1 exactly when it is negative.
- R5: `bad_o` is 1 exactly when `dec_i`=1 and either operand is above 9. It is always 0 in hex mode.
- R6: In decimal mode with a bad operand, the output is still fully determined by the correction rule, applied to the full binary value s. In add, when s > 9 the result is `(s + 6) mod 16` and `cy_o`=1. In subtract, when s < 0 the result is `(s - 6) mod 16` and `cy_o`=1. In every other case the result is s and `cy_o`=0.
- R7: Hex mode applies no decimal correction. For example, 9 + 1 gives `dig_o`=A with `cy_o`=0.
- R8: The block holds no state. The same input vector gives the same outputs whatever inputs came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa_i | input | 4 | First operand (minuend in subtract) |
| opb_i | input | 4 | Second operand (subtrahend in subtract) |
| cy_i | input | 1 | Carry in (add) or borrow in (subtract) |
| sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| dec_i | input | 1 | Radix select: 0 hexadecimal, 1 decimal |
| dig_o | output | 4 | Result digit |
| cy_o | output | 1 | Carry out (add) or borrow out (subtract) |
| bad_o | output | 1 | Decimal operand above 9 |

## Verification
Every output is due in the same cycle as the stimulus that produces it, zero clock edges later, because no register lies between any input and any output. The bench changes inputs just after a rising edge and compares outputs at the following falling edge, which gives the ripple and correction chain half a period to settle. It never waits for an edge to produce a result. All input combinations are swept against an independent arithmetic model, and a sequence that returns to an earlier vector confirms that history has no effect.

// File: rtl/adsu_pkg.sv
// Package: shared constants for the dual-radix digit adder-subtractor.
// Assumes a 4-bit digit, so a hex digit spans 16 codes and a decimal digit 10.
package adsu_pkg;
    localparam int HEX_RADIX = 16;
    localparam int DEC_RADIX = 10;
    localparam int DEC_MAX   = DEC_RADIX - 1;
    localparam int DEC_ADJ   = HEX_RADIX - DEC_RADIX;
endpackage

// File: rtl/adsu_fa_cell.sv
// Module: one-bit full-adder cell.
// Sum is the odd parity of the three inputs, and carry is their majority.
// Assumes nothing beyond single-bit inputs.
module adsu_fa_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic s,
    output logic c
);
    // Sum and majority carry.
    always_comb begin
        s = x ^ y ^ z;
        c = (x & y) | (x & z) | (y & z);
    end
endmodule

// File: rtl/adsu_fs_cell.sv
// Module: one-bit full-subtractor cell computing x - y - z.
// Difference is the odd parity of the inputs. Borrow is x'y + x'z + yz.
// Assumes x is the minuend bit, y the subtrahend bit and z the incoming borrow.
module adsu_fs_cell (
    input  logic x,
    input  logic y,
    input  logic z,
    output logic d,
    output logic b
);
    // Difference and borrow.
    always_comb begin
        d = x ^ y ^ z;
        b = (~x & y) | (~x & z) | (y & z);
    end
endmodule

// File: rtl/adsu_ripple.sv
// Module: W-bit ripple add/subtract built from bit cells.
// Every bit position holds both a full-adder and a full-subtractor cell.
// sub_sel picks which cell drives the result bit and the chain into the next bit.
// Assumes cin is a carry when adding and a borrow when subtracting.
module adsu_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub_sel,
    output logic [W-1:0] r,
    output logic         cout
);
    logic [W:0]   chain;
    logic [W-1:0] add_s;
    logic [W-1:0] add_c;
    logic [W-1:0] sub_d;
    logic [W-1:0] sub_b;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        adsu_fa_cell fa_i (
            .x(x[i]),
            .y(y[i]),
            .z(chain[i]),
            .s(add_s[i]),
            .c(add_c[i])
        );
        adsu_fs_cell fs_i (
            .x(x[i]),
            .y(y[i]),
            .z(chain[i]),
            .d(sub_d[i]),
            .b(sub_b[i])
        );
        // Select the active cell for this bit.
        always_comb begin
            r[i]        = sub_sel ? sub_d[i] : add_s[i];
            chain[i+1]  = sub_sel ? sub_b[i] : add_c[i];
        end
    end

    assign cout = chain[W];
endmodule

// File: rtl/adsu_digit_chk.sv
// Module: flags a digit that lies above the largest decimal code.
// Assumes W is 4, so that a decimal digit covers 0 to 9.
module adsu_digit_chk #(
    parameter int W = 4
) (
    input  logic [W-1:0] dig,
    output logic         over
);
    localparam logic [W-1:0] LIMIT = W'(adsu_pkg::DEC_MAX);

    // Compare against the decimal limit.
    always_comb over = (dig > LIMIT);
endmodule

// File: rtl/adsu_dec_fix.sv
// Module: decimal correction after the binary ripple.
// In add, a carry, or a raw value of ten or more, calls for adding six.
// A raw value of ten or more is exactly the case where raw + 6 carries.
// In subtract, a borrow calls for subtracting six modulo 16.
// In hex mode the raw value and carry pass through unchanged.
// Assumes W is 4.
module adsu_dec_fix #(
    parameter int W = 4
) (
    input  logic [W-1:0] raw,
    input  logic         raw_c,
    input  logic         sub_sel,
    input  logic         dec_sel,
    output logic [W-1:0] res,
    output logic         co
);
    localparam logic [W-1:0] ADJ = W'(adsu_pkg::DEC_ADJ);

    logic [W-1:0] fixed;
    logic         fix_c;
    logic         need;

    adsu_ripple #(.W(W)) adj_i (
        .x(raw),
        .y(ADJ),
        .cin(1'b0),
        .sub_sel(sub_sel),
        .r(fixed),
        .cout(fix_c)
    );

    // Decide on the correction and pick the output.
    always_comb begin
        need = sub_sel ? raw_c : (raw_c | fix_c);
        if (dec_sel) begin
            res = need ? fixed : raw;
            co  = need;
        end else begin
            res = raw;
            co  = raw_c;
        end
    end
endmodule

// File: rtl/bcdhex_addsub.sv
// Module: dual-radix single-digit adder-subtractor (top).
// A binary ripple of bit cells feeds a decimal correction stage.
// The bad-operand flag is raised in decimal mode when either operand exceeds 9.
// Purely combinational, so it has no clock and no reset.
// Assumes DIGIT_W is 4.
module bcdhex_addsub #(
    parameter int DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] opa_i,
    input  logic [DIGIT_W-1:0] opb_i,
    input  logic               cy_i,
    input  logic               sub_i,
    input  logic               dec_i,
    output logic [DIGIT_W-1:0] dig_o,
    output logic               cy_o,
    output logic               bad_o
);
    logic [DIGIT_W-1:0] raw;
    logic               raw_c;
    logic               a_over;
    logic               b_over;

    adsu_ripple #(.W(DIGIT_W)) core_i (
        .x(opa_i),
        .y(opb_i),
        .cin(cy_i),
        .sub_sel(sub_i),
        .r(raw),
        .cout(raw_c)
    );

    adsu_dec_fix #(.W(DIGIT_W)) fix_i (
        .raw(raw),
        .raw_c(raw_c),
        .sub_sel(sub_i),
        .dec_sel(dec_i),
        .res(dig_o),
        .co(cy_o)
    );

    adsu_digit_chk #(.W(DIGIT_W)) chk_a_i (.dig(opa_i), .over(a_over));
    adsu_digit_chk #(.W(DIGIT_W)) chk_b_i (.dig(opb_i), .over(b_over));

    // Bad-operand flag, decimal mode only.
    always_comb bad_o = dec_i & (a_over | b_over);
endmodule

// File: rtl/bcdhex_addsub_chk.sv
// Module: assertion checker for bcdhex_addsub, attached to it with bind.
// The block is combinational, so every check is an immediate assertion.
// Each one is evaluated whenever the ports change.
module bcdhex_addsub_chk #(
    parameter int W = 4
) (
    input logic [W-1:0] opa_i,
    input logic [W-1:0] opb_i,
    input logic         cy_i,
    input logic         sub_i,
    input logic         dec_i,
    input logic [W-1:0] dig_o,
    input logic         cy_o,
    input logic         bad_o
);
    logic [W:0] add5;
    logic [W:0] need5;
    logic [W:0] diff5;
    logic       valid;

    // Port-level relations checked on every input change.
    always_comb begin
        add5  = (W+1)'(opa_i) + (W+1)'(opb_i) + (W+1)'(cy_i);
        need5 = (W+1)'(opb_i) + (W+1)'(cy_i);
        diff5 = (W+1)'(opa_i) - need5;
        valid = (opa_i <= W'(9)) && (opb_i <= W'(9));
        if (!dec_i && !sub_i)
            assert_hex_sum_R1: assert ({cy_o, dig_o} == add5);
        if (!dec_i && sub_i)
            assert_hex_diff_R2: assert (dig_o == diff5[W-1:0] && cy_o == ((W+1)'(opa_i) < need5));
        if (dec_i && valid)
            assert_dec_digit_range_R3: assert (dig_o <= W'(9));
        if (dec_i && sub_i && valid)
            assert_dec_borrow_R4: assert (cy_o == ((W+1)'(opa_i) < need5));
        assert_bad_flag_R5: assert (bad_o == (dec_i && !valid));
        if (!dec_i)
            assert_hex_no_fix_R7: assert (!bad_o);
    end
endmodule

bind bcdhex_addsub bcdhex_addsub_chk #(.W(DIGIT_W)) chk_i (
    .opa_i(opa_i),
    .opb_i(opb_i),
    .cy_i(cy_i),
    .sub_i(sub_i),
    .dec_i(dec_i),
    .dig_o(dig_o),
    .cy_o(cy_o),
    .bad_o(bad_o)
);

// File: tb/bcdhex_addsub_tb.sv
// Bench: bcdhex_addsub_tb_top, a self-checking bench for bcdhex_addsub.
// Inputs change after a rising edge and outputs are compared at the next falling edge.
module bcdhex_addsub_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] opa = '0;
    logic [3:0] opb = '0;
    logic       cy = 1'b0;
    logic       sub = 1'b0;
    logic       dec = 1'b0;
    logic [3:0] dig;
    logic       cyo;
    logic       bad;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    bcdhex_addsub dut_i (
        .opa_i(opa), .opb_i(opb), .cy_i(cy), .sub_i(sub), .dec_i(dec),
        .dig_o(dig), .cy_o(cyo), .bad_o(bad)
    );

    // Vector: {dec, sub, cy, a, b, exp_dig, exp_cy, exp_bad}
    localparam logic [16:0] VEC [16] = '{
        {1'b0,1'b0,1'b0,4'h0,4'h0,4'h0,1'b0,1'b0},  // R1
        {1'b0,1'b0,1'b1,4'hF,4'hF,4'hF,1'b1,1'b0},  // R1
        {1'b0,1'b0,1'b0,4'h9,4'h1,4'hA,1'b0,1'b0},  // R7
        {1'b0,1'b1,1'b0,4'h3,4'h5,4'hE,1'b1,1'b0},  // R2
        {1'b0,1'b1,1'b1,4'h0,4'h0,4'hF,1'b1,1'b0},  // R2
        {1'b0,1'b1,1'b1,4'h9,4'h3,4'h5,1'b0,1'b0},  // R2
        {1'b1,1'b0,1'b1,4'h9,4'h9,4'h9,1'b1,1'b0},  // R3
        {1'b1,1'b0,1'b0,4'h5,4'h4,4'h9,1'b0,1'b0},  // R3
        {1'b1,1'b0,1'b0,4'h5,4'h5,4'h0,1'b1,1'b0},  // R3
        {1'b1,1'b1,1'b1,4'h0,4'h9,4'h0,1'b1,1'b0},  // R4
        {1'b1,1'b1,1'b0,4'h7,4'h2,4'h5,1'b0,1'b0},  // R4
        {1'b1,1'b1,1'b0,4'h3,4'h8,4'h5,1'b1,1'b0},  // R4
        {1'b1,1'b0,1'b0,4'hF,4'h1,4'h6,1'b1,1'b1},  // R6
        {1'b1,1'b1,1'b0,4'hA,4'h0,4'hA,1'b0,1'b1},  // R6
        {1'b1,1'b1,1'b0,4'h0,4'hC,4'hE,1'b1,1'b1},  // R6
        {1'b0,1'b0,1'b0,4'hF,4'h0,4'hF,1'b0,1'b0}   // R5
    };

    // Independent model: returns {bad, cy, dig}.
    function automatic logic [5:0] model(input logic d, input logic s, input logic c,
                                         input logic [3:0] a, input logic [3:0] b);
        int v;
        logic [3:0] r;
        logic co;
        v = s ? (int'(a) - int'(b) - int'(c)) : (int'(a) + int'(b) + int'(c));
        if (!d) begin
            r  = 4'(v & 15);
            co = s ? (v < 0) : (v > 15);
        end else if (!s && v > 9) begin
            r = 4'((v + 6) & 15); co = 1'b1;
        end else if (s && v < 0) begin
            r = 4'((v - 6) & 15); co = 1'b1;
        end else begin
            r = 4'(v & 15); co = 1'b0;
        end
        return {d && (a > 4'd9 || b > 4'd9), co, r};
    endfunction

    task automatic apply(input logic d, input logic s, input logic c,
                         input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        dec <= d; sub <= s; cy <= c; opa <= a; opb <= b;
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [5:0] exp);
        n_chk++;
        if ({bad, cyo, dig} !== exp) begin
            n_bad++;
            $display("FAIL %s: dec=%0b sub=%0b cy=%0b a=%h b=%h got bad/cy/dig=%b/%b/%h exp %b/%b/%h",
                     req, dec, sub, cy, opa, opb, bad, cyo, dig, exp[5], exp[4], exp[3:0]);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, got done=0 exp done=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        // Held-reset state: all-zero inputs give all-zero outputs (R1).
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", 6'b000000);
        rst_n <= 1'b1;

        // Table walk.
        for (int i = 0; i < 16; i++) begin
            logic [16:0] v;
            v = VEC[i];
            apply(v[16], v[15], v[14], v[13:10], v[9:6]);
            check("R1-table", {v[0], v[1], v[5:2]});
        end

        // Exhaustive sweep against the model (covers R1 R2 R3 R4 R5 R6 R7).
        for (int m = 0; m < 8; m++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    logic d, s, c;
                    d = m[2]; s = m[1]; c = m[0];
                    apply(d, s, c, 4'(a), 4'(b));
                    if (!d)
                        check(s ? "R2 sweep" : "R1 sweep", model(d, s, c, 4'(a), 4'(b)));
                    else if (a > 9 || b > 9)
                        check("R6 sweep", model(d, s, c, 4'(a), 4'(b)));
                    else
                        check(s ? "R4 sweep" : "R3 sweep", model(d, s, c, 4'(a), 4'(b)));
                end
            end
        end

        // Directed: bad flag is 0 in hex mode even for operands above 9 (R5).
        apply(1'b0, 1'b1, 1'b0, 4'hE, 4'hB);
        check("R5 hex flag", {1'b0, 1'b0, 4'h3});
        apply(1'b1, 1'b0, 1'b0, 4'h2, 4'hA);
        check("R5 dec flag", {1'b1, 1'b1, 4'h2});

        // Directed: no correction in hex mode (R7).
        apply(1'b0, 1'b0, 1'b0, 4'h8, 4'h7);
        check("R7 hex F", {1'b0, 1'b0, 4'hF});

        // History independence: same vector after different history (R8).
        apply(1'b1, 1'b0, 1'b1, 4'h6, 4'h7);
        check("R8 first", {1'b0, 1'b1, 4'h4});
        apply(1'b0, 1'b1, 1'b1, 4'hF, 4'hF);
        check("R8 between", {1'b0, 1'b1, 4'hF});
        apply(1'b1, 1'b0, 1'b1, 4'h6, 4'h7);
        check("R8 repeat", {1'b0, 1'b1, 4'h4});

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule